// File: doc/BRIEF.md
# Serial-Controlled SAR Conversion Sequencer

This block is the digital half of a serial successive-approximation converter. A host frames a transaction with an active-low chip select and clocks an 8-bit command into `din` on serial clock rising edges. The command picks one of eight analog channels and chooses either single-ended operation (negative input on the common node) or differential operation (two adjacent channels). While the command arrives, the block moves the analog multiplexer and the track/hold switch at fixed serial-clock falling edges. It then runs a binary search: it presents a trial code to the DAC and reads a one-bit comparator.

Two conversion timings are offered. With the serial clock as the conversion clock, the search is paced by both edges of the host's serial clock and ends on a fixed falling edge. With the internal clock, it is paced by a divided system clock and completion is flagged by a rising strobe. Either way, the 14-bit result then leaves on `dout` MSB first. The serial inputs are taken to be synchronous to `clk` and slow against it, since each level must last at least two `clk` cycles.

Top module: `serial_sar_ctrl`

## Requirements
- R1: While chip select is low, `din` bits sampled at rising edges before the first 1 are ignored. The first 1 is the start bit. The command is then, MSB first: start, channel field (3 bits, MSB first), mode bit (1 = single-ended, 0 = differential), timing bit (1 = internal clock, 0 = serial clock), two unused bits.
- R2: The multiplexer select outputs keep their previous value through the fourth falling edge after the start bit. They take the new channel on the fifth falling edge, with `th_hold` low (track).
- R3: In single-ended mode, `mux_pos_sel` equals the channel field and `mux_neg_com` is 1.
- R4: In differential mode, `mux_neg_com` is 0, `mux_pos_sel` equals the channel field and `mux_neg_sel` equals the channel field with its LSB inverted.
- R5: `th_hold` and `mux_open` stay low through the seventh falling edge after the start bit and go high on the eighth.
- R6: The conversion takes 15 conversion-clock steps and its result equals the code at which the comparator (1 when the input is at or above `dac_code`) flips. In serial-clock mode, the steps are the last 15 serial clock edges up to and including falling edge 18. `sstrb` is low after falling edge 17 and high after falling edge 18.
- R7: In internal-clock mode, each step lasts INT_DIV `clk` cycles. `sstrb` stays low for the first 50 cycles after hold and is high 75 cycles after hold.
- R8: At completion, `th_hold` and `mux_open` return low and the multiplexer selects keep the last commanded channel, also after chip select rises.
- R9: From completion, `dout` carries result bit 13. Each later serial clock falling edge advances it by one bit toward bit 0.
- R10: `dout` is 0 whenever chip select is high.
- R11: Raising chip select at any point returns the block to idle: `th_hold`, `mux_open` and `sstrb` low. A following command is handled normally.
- R12: After reset, `th_hold`, `mux_open`, `sstrb` and `dout` are 0, `mux_pos_sel` is 0 and `mux_neg_com` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, high aborts |
| sclk | input | 1 | Host serial clock |
| din | input | 1 | Serial command data |
| cmp_i | input | 1 | Comparator decision, 1 when input is at or above `dac_code` |
| dout | output | 1 | Serial result, MSB first |
| sstrb | output | 1 | Completion strobe, rises at end of conversion |
| th_hold | output | 1 | Track/hold control, 1 = hold |
| mux_open | output | 1 | Multiplexer disconnect during conversion |
| mux_pos_sel | output | CH_W | Channel on the positive input |
| mux_neg_sel | output | CH_W | Channel on the negative input in differential mode |
| mux_neg_com | output | 1 | 1 = negative input on common node |
| dac_code | output | RES_W | Trial code for the comparator DAC |

## Verification
The hardest conditions to reach are the edge-exact moments: the multiplexer moves on falling edge 5, hold starts on falling edge 8 and completion comes on falling edge 18. An off-by-one there is invisible unless the outputs are looked at after every single serial edge. The bench drives the serial clock one edge at a time with several system clocks per level and samples after each falling edge, including the one just before each expected change. It sweeps every channel with both input modes and both timing modes, using analog codes that include both rails. Aborts are placed inside the command and inside a running conversion, and each is followed by a clean transaction.

// File: rtl/ssc_pkg.sv
// Shared types for the serial SAR sequencer.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package ssc_pkg;

    // Transaction phases of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_CONV = 2'd2,
        ST_READ = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ssc_edge_det.sv
// Serial clock edge detector.
// Produces one-cycle rise and fall pulses from a level that is already
// synchronous to clk; each level is assumed to last at least two cycles.
module ssc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_q;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Edge pulses from current versus previous level.
    always_comb begin
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end

endmodule

// File: rtl/ssc_mux_map.sv
// Maps the command channel field and input mode to multiplexer selects.
// Differential mode pairs a channel with its LSB-inverted neighbour.
module ssc_mux_map #(
    parameter int CH_W = 3
)(
    input  logic [CH_W-1:0] chan_i,
    input  logic            single_i,
    output logic [CH_W-1:0] pos_o,
    output logic [CH_W-1:0] neg_o,
    output logic            neg_com_o
);

    localparam logic [CH_W-1:0] PAIR_FLIP = CH_W'(1);

    // Positive side follows the field; negative side by mode.
    always_comb begin
        pos_o     = chan_i;
        neg_com_o = single_i;
        neg_o     = single_i ? '0 : (chan_i ^ PAIR_FLIP);
    end

endmodule

// File: rtl/ssc_step_gen.sv
// Conversion step pacing.
// Serial-clock mode: a step on each serial edge inside the window that
// ends on falling edge DONE_FALL. Internal mode: a step every INT_DIV
// clk cycles. Assumes fall_cnt_i holds falling edges seen so far.
module ssc_step_gen #(
    parameter int STEPS     = 15,
    parameter int INT_DIV   = 4,
    parameter int DONE_FALL = 18,
    parameter int FCNT_W    = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              int_mode_i,
    input  logic              s_rise_i,
    input  logic              s_fall_i,
    input  logic [FCNT_W-1:0] fall_cnt_i,
    output logic              step_o
);

    localparam int DIV_W    = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam int FALL_MIN = DONE_FALL - (STEPS + 1) / 2;
    localparam int RISE_MIN = DONE_FALL - STEPS / 2;

    logic [DIV_W-1:0] div_cnt;
    logic             div_tick;
    logic             ext_tick;

    // Internal divider, restarted whenever no conversion runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || !int_mode_i) div_cnt <= '0;
        else if (div_tick)                   div_cnt <= '0;
        else                                 div_cnt <= div_cnt + 1'b1;
    end

    // Step selection for the active timing mode.
    always_comb begin
        div_tick = (div_cnt == DIV_W'(INT_DIV - 1));
        ext_tick = (s_fall_i && (fall_cnt_i >= FCNT_W'(FALL_MIN))) ||
                   (s_rise_i && (fall_cnt_i >= FCNT_W'(RISE_MIN)));
        step_o   = run_i && (int_mode_i ? div_tick : ext_tick);
    end

endmodule

// File: rtl/ssc_sar_core.sv
// Binary-search register and result shifter.
// Steps 0..RES_W-1 each decide one bit MSB first from the comparator;
// step RES_W copies the result into the output shift register.
module ssc_sar_core #(
    parameter int RES_W = 14
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             cmp_i,
    input  logic             shift_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic             done_o,
    output logic             dout_o
);

    localparam int IDX_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] out_sr;
    logic [IDX_W-1:0] idx_q;

    // Search state: clear on start, decide one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            idx_q <= '0;
        end else if (start_i) begin
            res_q <= '0;
            idx_q <= '0;
        end else if (step_i && (idx_q < IDX_W'(RES_W))) begin
            res_q[RES_W - 1 - int'(idx_q)] <= cmp_i;
            idx_q <= idx_q + 1'b1;
        end
    end

    // Output shifter: load at completion, advance on request.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_sr <= '0;
        else if (done_o)  out_sr <= res_q;
        else if (shift_i) out_sr <= {out_sr[RES_W-2:0], 1'b0};
    end

    // Trial code: decided bits plus the bit under test.
    always_comb begin
        for (int k = 0; k < RES_W; k++) begin
            dac_code_o[k] = res_q[k] | ((int'(idx_q) + k) == RES_W - 1);
        end
        done_o = step_i && (idx_q == IDX_W'(RES_W));
        dout_o = out_sr[RES_W-1];
    end

endmodule

// File: rtl/serial_sar_ctrl.sv
// Top of the serial SAR sequencer.
// Receives the command byte, moves the multiplexer and track/hold at
// fixed serial falling edges, runs the search and serialises the result.
// Assumes cs_n, sclk and din are synchronous to clk and CMD_W >= CH_W+3.
module serial_sar_ctrl
    import ssc_pkg::*;
#(
    parameter int RES_W         = 14,
    parameter int CH_W          = 3,
    parameter int CMD_W         = 8,
    parameter int INT_DIV       = 4,
    parameter int EXT_DONE_FALL = 18
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             cmp_i,
    output logic             dout,
    output logic             sstrb,
    output logic             th_hold,
    output logic             mux_open,
    output logic [CH_W-1:0]  mux_pos_sel,
    output logic [CH_W-1:0]  mux_neg_sel,
    output logic             mux_neg_com,
    output logic [RES_W-1:0] dac_code
);

    localparam int STEPS     = RES_W + 1;
    localparam int SEL_FALL  = CH_W + 2;
    localparam int HOLD_FALL = CMD_W;
    localparam int MODE_BIT  = CMD_W - CH_W - 3;
    localparam int FCNT_W    = $clog2(EXT_DONE_FALL + 1);

    seq_state_t        state;
    logic [CMD_W-1:0]  cmd_sr;
    logic [FCNT_W-1:0] fall_cnt;
    logic [FCNT_W-1:0] fall_nxt;
    logic              int_mode;
    logic              s_rise, s_fall;
    logic              sar_start, sar_step, sar_done, sar_shift, sar_dout;
    logic [CH_W-1:0]   map_pos, map_neg;
    logic              map_com;

    ssc_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    ssc_mux_map #(.CH_W(CH_W)) u_map (
        .chan_i    (cmd_sr[CH_W:1]),
        .single_i  (cmd_sr[0]),
        .pos_o     (map_pos),
        .neg_o     (map_neg),
        .neg_com_o (map_com)
    );

    ssc_step_gen #(
        .STEPS     (STEPS),
        .INT_DIV   (INT_DIV),
        .DONE_FALL (EXT_DONE_FALL),
        .FCNT_W    (FCNT_W)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      ((state == ST_CONV) && !cs_n),
        .int_mode_i (int_mode),
        .s_rise_i   (s_rise),
        .s_fall_i   (s_fall),
        .fall_cnt_i (fall_cnt),
        .step_o     (sar_step)
    );

    ssc_sar_core #(.RES_W(RES_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (sar_start),
        .step_i     (sar_step),
        .cmp_i      (cmp_i),
        .shift_i    (sar_shift),
        .dac_code_o (dac_code),
        .done_o     (sar_done),
        .dout_o     (sar_dout)
    );

    // Edge-count arithmetic and handoff pulses to the search core.
    always_comb begin
        fall_nxt  = fall_cnt + 1'b1;
        sar_start = !cs_n && (state == ST_CMD) && s_fall &&
                    (fall_nxt == FCNT_W'(HOLD_FALL));
        sar_shift = !cs_n && (state == ST_READ) && s_fall;
        dout      = !cs_n && (state == ST_READ) && sar_dout;
    end

    // Transaction sequencing, multiplexer and track/hold control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cmd_sr      <= '0;
            fall_cnt    <= '0;
            int_mode    <= 1'b0;
            th_hold     <= 1'b0;
            mux_open    <= 1'b0;
            sstrb       <= 1'b0;
            mux_pos_sel <= '0;
            mux_neg_sel <= '0;
            mux_neg_com <= 1'b1;
        end else if (cs_n) begin
            state    <= ST_IDLE;
            th_hold  <= 1'b0;
            mux_open <= 1'b0;
            sstrb    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (s_rise && din) begin
                        cmd_sr   <= CMD_W'(1);
                        fall_cnt <= '0;
                        state    <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (s_rise) cmd_sr <= {cmd_sr[CMD_W-2:0], din};
                    if (s_fall) begin
                        fall_cnt <= fall_nxt;
                        if (fall_nxt == FCNT_W'(SEL_FALL)) begin
                            mux_pos_sel <= map_pos;
                            mux_neg_sel <= map_neg;
                            mux_neg_com <= map_com;
                        end
                        if (fall_nxt == FCNT_W'(HOLD_FALL)) begin
                            th_hold  <= 1'b1;
                            mux_open <= 1'b1;
                            int_mode <= cmd_sr[MODE_BIT];
                            state    <= ST_CONV;
                        end
                    end
                end
                ST_CONV: begin
                    if (s_fall) fall_cnt <= fall_nxt;
                    if (sar_done) begin
                        th_hold  <= 1'b0;
                        mux_open <= 1'b0;
                        sstrb    <= 1'b1;
                        state    <= ST_READ;
                    end
                end
                ST_READ: begin
                    state <= ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ssc_checker.sv
// Property checker for serial_sar_ctrl, attached by bind below.
// Observes ports only.
module ssc_checker #(
    parameter int CH_W = 3
)(
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            sclk,
    input logic            dout,
    input logic            sstrb,
    input logic            th_hold,
    input logic            mux_open,
    input logic [CH_W-1:0] mux_pos_sel,
    input logic [CH_W-1:0] mux_neg_sel,
    input logic            mux_neg_com
);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!th_hold && !mux_open && !sstrb));

    // R10
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout);

    // R8
    strobe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sstrb) |-> (!th_hold && !mux_open));

    // R5
    hold_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(th_hold) |-> (!sclk && !cs_n));

    // R4
    diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_neg_com |-> ((mux_pos_sel ^ mux_neg_sel) == CH_W'(1)));

    // R2
    mux_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_pos_sel) |-> (!sclk && !th_hold && !cs_n));

endmodule

bind serial_sar_ctrl ssc_checker #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .dout        (dout),
    .sstrb       (sstrb),
    .th_hold     (th_hold),
    .mux_open    (mux_open),
    .mux_pos_sel (mux_pos_sel),
    .mux_neg_sel (mux_neg_sel),
    .mux_neg_com (mux_neg_com)
);

// File: tb/serial_sar_ctrl_tb.sv
`timescale 1ns/1ps
module serial_sar_ctrl_tb;

    localparam int RES_W = 14;
    localparam int CH_W  = 3;
    localparam int HALF  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic             din = 1'b0;
    logic             cmp;
    logic             dout, sstrb, th_hold, mux_open, mux_neg_com;
    logic [CH_W-1:0]  mux_pos_sel, mux_neg_sel;
    logic [RES_W-1:0] dac_code;
    logic [RES_W-1:0] vin = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_pos = 0;

    always #2 clk = ~clk;

    // Analog comparator model.
    assign cmp = (vin >= dac_code);

    serial_sar_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cmp_i(cmp), .dout(dout), .sstrb(sstrb), .th_hold(th_hold),
        .mux_open(mux_open), .mux_pos_sel(mux_pos_sel),
        .mux_neg_sel(mux_neg_sel), .mux_neg_com(mux_neg_com),
        .dac_code(dac_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rise(input logic b);
        din = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic fall();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_tx();
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Full transaction with edge-exact checks.
    task automatic run_conv(input int ch, input bit sgl, input bit im,
                            input int v, input bit lead0);
        logic [7:0] cmd;
        int got;
        vin = RES_W'(v);
        cmd = {1'b1, 3'(ch), sgl, im, 2'b00};
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        if (lead0) begin
            rise(1'b0); fall(); rise(1'b0); fall();
            chk("R1 leading zero ignored, no hold", th_hold, 0);
            chk("R1 leading zero ignored, mux kept", mux_pos_sel, prev_pos);
        end
        for (int i = 7; i >= 0; i--) begin
            rise(cmd[i]);
            fall();
            if (8 - i == 4) chk("R2 mux unchanged at fall 4", mux_pos_sel, prev_pos);
            if (8 - i == 5) begin
                chk("R2 mux switched at fall 5", mux_pos_sel, ch);
                chk("R2 track at fall 5", th_hold, 0);
                if (sgl) chk("R3 single-ended neg on common", mux_neg_com, 1);
                else begin
                    chk("R4 differential neg not common", mux_neg_com, 0);
                    chk("R4 differential pair", mux_neg_sel, ch ^ 1);
                end
            end
            if (8 - i == 7) chk("R5 still tracking at fall 7", th_hold, 0);
            if (8 - i == 8) begin
                chk("R5 hold at fall 8", th_hold, 1);
                chk("R5 mux open at fall 8", mux_open, 1);
            end
        end
        if (!im) begin
            for (int f = 9; f <= 18; f++) begin
                rise(1'b0);
                fall();
                if (f == 17) chk("R6 not complete at fall 17", sstrb, 0);
            end
            chk("R6 complete at fall 18", sstrb, 1);
        end else begin
            repeat (50) @(negedge clk);
            chk("R7 internal still converting", sstrb, 0);
            chk("R7 hold during conversion", th_hold, 1);
            repeat (25) @(negedge clk);
            chk("R7 internal complete", sstrb, 1);
        end
        chk("R8 track after completion", th_hold, 0);
        chk("R8 mux closed after completion", mux_open, 0);
        chk("R8 mux keeps channel", mux_pos_sel, ch);
        got = 0;
        chk("R9 first result bit", dout, (v >> 13) & 1);
        got = int'(dout);
        for (int b = 12; b >= 0; b--) begin
            rise(1'b0);
            fall();
            chk("R9 result bit", dout, (v >> b) & 1);
            got = (got << 1) | int'(dout);
        end
        chk("R6 result word", got, v);
        end_tx();
        chk("R10 dout low with cs high", dout, 0);
        chk("R11 strobe low after cs high", sstrb, 0);
        chk("R8 mux kept after cs high", mux_pos_sel, ch);
        prev_pos = ch;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk("R12 th_hold", th_hold, 0);
        chk("R12 mux_open", mux_open, 0);
        chk("R12 sstrb", sstrb, 0);
        chk("R12 dout", dout, 0);
        chk("R12 mux_pos_sel", mux_pos_sel, 0);
        chk("R12 mux_neg_com", mux_neg_com, 1);

        // Sweep channels, input modes and timing modes.
        for (int im = 0; im < 2; im++)
            for (int sgl = 0; sgl < 2; sgl++)
                for (int ch = 0; ch < 8; ch++)
                    run_conv(ch, sgl[0], im[0],
                             (ch * 2221 + sgl * 5003 + im * 7919 + 1) % 16384,
                             ch[0]);
        // Rails.
        run_conv(5, 1'b1, 1'b0, 0, 1'b0);
        run_conv(2, 1'b0, 1'b0, 16383, 1'b0);
        run_conv(7, 1'b1, 1'b1, 16383, 1'b0);
        run_conv(0, 1'b0, 1'b1, 0, 1'b0);

        // R11 abort inside the command byte, after the mux moved.
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        begin
            logic [7:0] cmd;
            cmd = {1'b1, 3'd6, 1'b1, 1'b0, 2'b00};
            for (int i = 7; i >= 2; i--) begin rise(cmd[i]); fall(); end
        end
        end_tx();
        chk("R11 abort in command: track", th_hold, 0);
        chk("R11 abort in command: mux closed", mux_open, 0);
        chk("R11 abort in command: channel kept", mux_pos_sel, 6);
        prev_pos = 6;

        // R11 abort during a serial-clock conversion.
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        begin
            logic [7:0] cmd;
            cmd = {1'b1, 3'd3, 1'b0, 1'b0, 2'b00};
            for (int i = 7; i >= 0; i--) begin rise(cmd[i]); fall(); end
            for (int f = 9; f <= 12; f++) begin rise(1'b0); fall(); end
        end
        chk("R11 converting before abort", th_hold, 1);
        end_tx();
        chk("R11 abort in conversion: track", th_hold, 0);
        chk("R11 abort in conversion: strobe low", sstrb, 0);
        chk("R10 abort: dout low", dout, 0);
        prev_pos = 3;

        // Recovery after aborts.
        run_conv(4, 1'b1, 1'b0, 9876, 1'b1);
        run_conv(1, 1'b0, 1'b1, 4321, 1'b0);

        summary();
    end

endmodule